// File: doc/BRIEF.md
# Byte Access Adapter for a Word-Only Memory

This block lets a processor-side port issue byte loads, byte stores, word loads and word stores against a memory that can only read or write a whole 32-bit word and has no per-byte write strobes. A word access is forwarded as one memory operation. A byte load becomes one word read; the block then returns the addressed byte in the low bits of the response, with the upper bits cleared. A byte store cannot change memory in one cycle. The block reads the containing word, splices the new byte into its lane, and writes the full word back.

Both sides use valid/ready handshakes. The memory read data comes back on a separate valid pulse at least one cycle after the read request is accepted. Writes complete when their request is accepted. The processor-side port takes one request at a time. It stays closed from the moment a request is accepted until that request's response has been taken. As a result, no other access can reach the memory between the read and the write-back of a byte store.

Top module: `byte_rmw_bridge`

## Requirements
- R1: After reset, `cpu_req_ready` is 1 and both `mem_req_valid` and `cpu_rsp_valid` are 0.
- R2: A byte load (`cpu_req_byte`=1, `cpu_req_write`=0) issues exactly one memory read and no write. It returns the byte of lane `cpu_req_addr[1:0]` in `cpu_rsp_rdata[7:0]`, with bits [31:8] zero. Lane 0 is word bits [7:0] and lane 3 is bits [31:24].
- R3: A byte store issues exactly one read, then exactly one write to the same word. The written word equals the word read, with only the addressed lane replaced by `cpu_req_wdata[7:0]`.
- R4: A word store (`cpu_req_byte`=0, `cpu_req_write`=1) issues exactly one write of `cpu_req_wdata` and no read.
- R5: A word load issues exactly one read and returns the full word unchanged.
- R6: `cpu_req_ready` stays 0 from the cycle after a request is accepted until its response handshake completes.
- R7: `mem_req_addr` carries the request's address with bits [1:0] forced to zero.
- R8: While `mem_req_valid` is 1 and `mem_req_ready` is 0, the request stays valid, and its address, direction and write data do not change.
- R9: While `cpu_rsp_valid` is 1 and `cpu_rsp_ready` is 0, the response stays valid and its data does not change.
- R10: Every store, byte or word, gets one response, and its `cpu_rsp_rdata` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_req_valid | input | 1 | Processor request present |
| cpu_req_ready | output | 1 | Adapter can accept a request |
| cpu_req_write | input | 1 | 1 = store, 0 = load |
| cpu_req_byte | input | 1 | 1 = byte access, 0 = word access |
| cpu_req_addr | input | ADDR_W | Byte address |
| cpu_req_wdata | input | DATA_W | Store data; byte stores use bits [7:0] |
| cpu_rsp_valid | output | 1 | Response present |
| cpu_rsp_ready | input | 1 | Processor takes the response |
| cpu_rsp_rdata | output | DATA_W | Load data, or zero for stores |
| mem_req_valid | output | 1 | Memory request present |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_write | output | 1 | 1 = word write, 0 = word read |
| mem_req_addr | output | ADDR_W | Word-aligned byte address |
| mem_req_wdata | output | DATA_W | Full word to write |
| mem_rsp_valid | input | 1 | Read data present (one-cycle pulse) |
| mem_rsp_rdata | input | DATA_W | Read data word |

## Verification
If the sequencer takes a wrong branch, the memory-side operation counts show it within the same access. A byte store that skips its read, or a word store that adds one, shows up before the response arrives. A wrong lane select or a broken merge leaves a corrupted neighbour byte, and a word load of the same address returns it one access later. If the busy state is lost too early, `cpu_req_ready` rises while a write-back or response is still pending. Checks made every cycle of every access catch this.

// File: rtl/rmw_pkg.sv
// Shared definitions for the byte access adapter.
// Assumes: one outstanding request at a time.
package rmw_pkg;

    // Sequencer states, one per phase of an access
    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_RD_REQ  = 3'd1,
        ST_RD_WAIT = 3'd2,
        ST_WRITE   = 3'd3,
        ST_RESP    = 3'd4
    } rmw_state_t;

    localparam int unsigned OCTET_W = 8;

endpackage

// File: rtl/rmw_lane_unit.sv
// Lane datapath: extracts one octet from a word (zero-extended) and builds
// a word with one octet replaced. Purely combinational.
// Assumes: DATA_W is a multiple of 8; lane 0 is the least significant octet.
module rmw_lane_unit
    import rmw_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    localparam int unsigned LANES  = DATA_W / OCTET_W,
    localparam int unsigned LANE_W = $clog2(LANES)
) (
    input  logic [DATA_W-1:0]  word_in,
    input  logic [LANE_W-1:0]  lane_sel,
    input  logic [OCTET_W-1:0] new_octet,
    output logic [DATA_W-1:0]  picked,
    output logic [DATA_W-1:0]  merged
);

    // One splice multiplexer per lane
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign merged[g*OCTET_W +: OCTET_W] =
            (lane_sel == LANE_W'(g)) ? new_octet : word_in[g*OCTET_W +: OCTET_W];
    end

    // Select the addressed octet and clear everything above it
    always_comb begin
        picked = '0;
        for (int i = 0; i < LANES; i++) begin
            if (lane_sel == LANE_W'(i)) begin
                picked[OCTET_W-1:0] = word_in[i*OCTET_W +: OCTET_W];
            end
        end
    end

endmodule

// File: rtl/rmw_sequencer.sv
// Access sequencer: moves through idle, read request, read wait, write and
// response phases. A byte store takes read then write; a word store skips
// the read; loads skip the write.
// Assumes: read data arrives at least one cycle after its request is accepted.
module rmw_sequencer
    import rmw_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_fire,
    input  logic       req_write,
    input  logic       req_byte,
    input  logic       op_write_q,
    input  logic       mem_req_ready,
    input  logic       mem_rsp_valid,
    input  logic       cpu_rsp_ready,
    output rmw_state_t state_q
);

    rmw_state_t state_d;

    // Next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (req_fire) begin
                    state_d = (req_write && !req_byte) ? ST_WRITE : ST_RD_REQ;
                end
            end
            ST_RD_REQ:  if (mem_req_ready) state_d = ST_RD_WAIT;
            ST_RD_WAIT: if (mem_rsp_valid) state_d = op_write_q ? ST_WRITE : ST_RESP;
            ST_WRITE:   if (mem_req_ready) state_d = ST_RESP;
            ST_RESP:    if (cpu_rsp_ready) state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

endmodule

// File: rtl/byte_rmw_bridge.sv
// Top of the byte access adapter. Turns byte and word requests into
// whole-word memory operations; byte stores become read, merge, write.
// Assumes: memory has no byte strobes; read data comes on a one-cycle pulse.
module byte_rmw_bridge
    import rmw_pkg::*;
#(
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned DATA_W = 32,
    localparam int unsigned LANES  = DATA_W / OCTET_W,
    localparam int unsigned LANE_W = $clog2(LANES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req_valid,
    output logic              cpu_req_ready,
    input  logic              cpu_req_write,
    input  logic              cpu_req_byte,
    input  logic [ADDR_W-1:0] cpu_req_addr,
    input  logic [DATA_W-1:0] cpu_req_wdata,
    output logic              cpu_rsp_valid,
    input  logic              cpu_rsp_ready,
    output logic [DATA_W-1:0] cpu_rsp_rdata,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic              mem_req_write,
    output logic [ADDR_W-1:0] mem_req_addr,
    output logic [DATA_W-1:0] mem_req_wdata,
    input  logic              mem_rsp_valid,
    input  logic [DATA_W-1:0] mem_rsp_rdata
);

    rmw_state_t         state_q;
    logic               req_fire;
    logic               rd_capture;
    logic [ADDR_W-1:0]  addr_q;
    logic               write_q;
    logic               byte_q;
    logic [OCTET_W-1:0] octet_q;
    logic [DATA_W-1:0]  wbuf_q;
    logic [DATA_W-1:0]  rsp_q;
    logic [DATA_W-1:0]  picked;
    logic [DATA_W-1:0]  merged;

    assign req_fire   = cpu_req_valid && cpu_req_ready;
    assign rd_capture = (state_q == ST_RD_WAIT) && mem_rsp_valid;

    rmw_sequencer u_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_fire      (req_fire),
        .req_write     (cpu_req_write),
        .req_byte      (cpu_req_byte),
        .op_write_q    (write_q),
        .mem_req_ready (mem_req_ready),
        .mem_rsp_valid (mem_rsp_valid),
        .cpu_rsp_ready (cpu_rsp_ready),
        .state_q       (state_q)
    );

    rmw_lane_unit #(.DATA_W(DATA_W)) u_lane (
        .word_in   (mem_rsp_rdata),
        .lane_sel  (addr_q[LANE_W-1:0]),
        .new_octet (octet_q),
        .picked    (picked),
        .merged    (merged)
    );

    // Latch the request, then capture read data as a merge or a load result
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            write_q <= 1'b0;
            byte_q  <= 1'b0;
            octet_q <= '0;
            wbuf_q  <= '0;
            rsp_q   <= '0;
        end else if (req_fire) begin
            addr_q  <= cpu_req_addr;
            write_q <= cpu_req_write;
            byte_q  <= cpu_req_byte;
            octet_q <= cpu_req_wdata[OCTET_W-1:0];
            wbuf_q  <= cpu_req_wdata;
            rsp_q   <= '0;
        end else if (rd_capture) begin
            if (write_q) begin
                wbuf_q <= merged;
            end else begin
                rsp_q <= byte_q ? picked : mem_rsp_rdata;
            end
        end
    end

    // Port decode from the sequencer state
    always_comb begin
        cpu_req_ready = (state_q == ST_IDLE);
        mem_req_valid = (state_q == ST_RD_REQ) || (state_q == ST_WRITE);
        mem_req_write = (state_q == ST_WRITE);
        cpu_rsp_valid = (state_q == ST_RESP);
    end

    assign mem_req_addr  = {addr_q[ADDR_W-1:LANE_W], {LANE_W{1'b0}}};
    assign mem_req_wdata = wbuf_q;
    assign cpu_rsp_rdata = rsp_q;

endmodule

// File: rtl/rmw_checker.sv
// Protocol and ordering checks for the byte access adapter, bound to its top.
// Keeps its own record of the accepted request's kind.
module rmw_checker #(
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cpu_req_valid,
    input logic              cpu_req_ready,
    input logic              cpu_req_write,
    input logic              cpu_req_byte,
    input logic              cpu_rsp_valid,
    input logic              cpu_rsp_ready,
    input logic [DATA_W-1:0] cpu_rsp_rdata,
    input logic              mem_req_valid,
    input logic              mem_req_ready,
    input logic              mem_req_write,
    input logic [ADDR_W-1:0] mem_req_addr,
    input logic [DATA_W-1:0] mem_req_wdata
);

    logic lat_write, lat_byte, seen_read;

    // Record the kind of the current access and whether its read went out
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat_write <= 1'b0;
            lat_byte  <= 1'b0;
            seen_read <= 1'b0;
        end else if (cpu_req_valid && cpu_req_ready) begin
            lat_write <= cpu_req_write;
            lat_byte  <= cpu_req_byte;
            seen_read <= 1'b0;
        end else if (mem_req_valid && mem_req_ready && !mem_req_write) begin
            seen_read <= 1'b1;
        end
    end

    assert_load_never_writes_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !lat_write) |-> !mem_req_write);

    assert_byte_load_zero_ext_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_rsp_valid && lat_byte && !lat_write) |-> (cpu_rsp_rdata[DATA_W-1:8] == '0));

    assert_store_reads_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && mem_req_write && lat_byte) |-> seen_read);

    assert_word_store_no_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && lat_write && !lat_byte) |-> mem_req_write);

    assert_busy_closes_port_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid || cpu_rsp_valid) |-> !cpu_req_ready);

    assert_word_aligned_R7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> (mem_req_addr[1:0] == 2'b00));

    assert_mem_req_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=>
            (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_write)
             && $stable(mem_req_wdata)));

    assert_rsp_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_rsp_valid && !cpu_rsp_ready) |=> (cpu_rsp_valid && $stable(cpu_rsp_rdata)));

    assert_store_rsp_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_rsp_valid && lat_write) |-> (cpu_rsp_rdata == '0));

endmodule

bind byte_rmw_bridge rmw_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cpu_req_valid (cpu_req_valid),
    .cpu_req_ready (cpu_req_ready),
    .cpu_req_write (cpu_req_write),
    .cpu_req_byte  (cpu_req_byte),
    .cpu_rsp_valid (cpu_rsp_valid),
    .cpu_rsp_ready (cpu_rsp_ready),
    .cpu_rsp_rdata (cpu_rsp_rdata),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_write (mem_req_write),
    .mem_req_addr  (mem_req_addr),
    .mem_req_wdata (mem_req_wdata)
);

// File: tb/tb_byte_rmw_bridge.sv
`timescale 1ns/1ps
module tb_byte_rmw_bridge;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_req_valid = 1'b0;
    logic        cpu_req_ready;
    logic        cpu_req_write = 1'b0;
    logic        cpu_req_byte = 1'b0;
    logic [15:0] cpu_req_addr = '0;
    logic [31:0] cpu_req_wdata = '0;
    logic        cpu_rsp_valid;
    logic        cpu_rsp_ready = 1'b0;
    logic [31:0] cpu_rsp_rdata;
    logic        mem_req_valid;
    logic        mem_req_ready;
    logic        mem_req_write;
    logic [15:0] mem_req_addr;
    logic [31:0] mem_req_wdata;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_rdata = '0;

    always #2.5 clk = ~clk;

    byte_rmw_bridge dut (
        .clk(clk), .rst_n(rst_n),
        .cpu_req_valid(cpu_req_valid), .cpu_req_ready(cpu_req_ready),
        .cpu_req_write(cpu_req_write), .cpu_req_byte(cpu_req_byte),
        .cpu_req_addr(cpu_req_addr), .cpu_req_wdata(cpu_req_wdata),
        .cpu_rsp_valid(cpu_rsp_valid), .cpu_rsp_ready(cpu_rsp_ready),
        .cpu_rsp_rdata(cpu_rsp_rdata),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
        .mem_req_wdata(mem_req_wdata),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_rdata(mem_rsp_rdata)
    );

    // Word-only memory model with optional alternate-cycle stalls
    logic [31:0] mem [0:15];
    logic [31:0] shadow [0:15];
    int          rd_cnt = 0;
    int          wr_cnt = 0;
    logic [15:0] last_addr = '0;
    bit          stall_mode = 1'b0;
    logic        gate_q = 1'b0;

    assign mem_req_ready = !stall_mode || gate_q;

    always @(posedge clk) begin
        gate_q <= ~gate_q;
        mem_rsp_valid <= 1'b0;
        if (mem_req_valid && mem_req_ready) begin
            last_addr <= mem_req_addr;
            if (mem_req_write) begin
                mem[mem_req_addr[5:2]] <= mem_req_wdata;
                wr_cnt <= wr_cnt + 1;
            end else begin
                mem_rsp_rdata <= mem[mem_req_addr[5:2]];
                mem_rsp_valid <= 1'b1;
                rd_cnt <= rd_cnt + 1;
            end
        end
    end

    int  n_checks = 0;
    int  n_fail = 0;
    bit  finished = 1'b0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // One processor access; returns data, memory op counts and handshake flags
    task automatic run_op(input bit wr, input bit bt, input logic [15:0] a,
                          input logic [31:0] wd, input int hold,
                          output logic [31:0] rd, output int nr, output int nw,
                          output bit leak, output bit unstable);
        int r0 = rd_cnt;
        int w0 = wr_cnt;
        int left = hold;
        bit done = 1'b0;
        bit have_first = 1'b0;
        logic [31:0] first = '0;
        leak = 1'b0;
        unstable = 1'b0;
        rd = '0;
        @(negedge clk);
        cpu_req_valid = 1'b1;
        cpu_req_write = wr;
        cpu_req_byte  = bt;
        cpu_req_addr  = a;
        cpu_req_wdata = wd;
        while (!cpu_req_ready) @(negedge clk);
        @(negedge clk);
        cpu_req_valid = 1'b0;
        while (!done) begin
            if (cpu_req_ready) leak = 1'b1;
            if (cpu_rsp_valid) begin
                if (have_first && cpu_rsp_rdata !== first) unstable = 1'b1;
                first = cpu_rsp_rdata;
                have_first = 1'b1;
                if (left > 0) begin
                    left--;
                end else begin
                    rd = cpu_rsp_rdata;
                    cpu_rsp_ready = 1'b1;
                    done = 1'b1;
                end
            end
            @(negedge clk);
        end
        cpu_rsp_ready = 1'b0;
        nr = rd_cnt - r0;
        nw = wr_cnt - w0;
    endtask

    task automatic test_reset();
        chk(cpu_req_ready === 1'b1, "R1", "req_ready after reset", {31'd0, cpu_req_ready}, 32'd1);
        chk(mem_req_valid === 1'b0, "R1", "mem_req_valid after reset", {31'd0, mem_req_valid}, 32'd0);
        chk(cpu_rsp_valid === 1'b0, "R1", "rsp_valid after reset", {31'd0, cpu_rsp_valid}, 32'd0);
    endtask

    task automatic test_byte_loads();
        logic [31:0] rd; int nr, nw; bit lk, us;
        for (int ln = 0; ln < 4; ln++) begin
            run_op(1'b0, 1'b1, 16'h0008 + 16'(ln), '0, 0, rd, nr, nw, lk, us);
            chk(rd === {24'd0, shadow[2][ln*8 +: 8]}, "R2", "byte load lane", rd,
                {24'd0, shadow[2][ln*8 +: 8]});
            chk(nr == 1 && nw == 0, "R2", "byte load op counts", 32'(nr*16 + nw), 32'h10);
            chk(!lk, "R6", "ready during byte load", {31'd0, lk}, 32'd0);
        end
    endtask

    task automatic test_byte_store(input int wi, input int ln, input logic [7:0] v,
                                   input bit stall, input string tag);
        logic [31:0] rd; int nr, nw; bit lk, us;
        stall_mode = stall;
        run_op(1'b1, 1'b1, 16'(wi*4 + ln), {24'hA5A5A5, v}, 0, rd, nr, nw, lk, us);
        shadow[wi][ln*8 +: 8] = v;
        chk(nr == 1 && nw == 1, "R3", {"byte store op counts ", tag}, 32'(nr*16 + nw), 32'h11);
        chk(rd === 32'd0, "R10", {"byte store response ", tag}, rd, 32'd0);
        chk(!lk, "R6", {"ready during byte store ", tag}, {31'd0, lk}, 32'd0);
        run_op(1'b0, 1'b0, 16'(wi*4 + 2), '0, 0, rd, nr, nw, lk, us);
        stall_mode = 1'b0;
        chk(rd === shadow[wi], "R3", {"merged word ", tag}, rd, shadow[wi]);
        chk(nr == 1 && nw == 0, "R5", {"word load op counts ", tag}, 32'(nr*16 + nw), 32'h10);
        chk(last_addr === 16'(wi*4), "R7", {"aligned address ", tag}, {16'd0, last_addr},
            32'(wi*4));
    endtask

    task automatic test_word_store();
        logic [31:0] rd; int nr, nw; bit lk, us;
        run_op(1'b1, 1'b0, 16'h0016, 32'hDEADBEEF, 0, rd, nr, nw, lk, us);
        shadow[5] = 32'hDEADBEEF;
        chk(nr == 0 && nw == 1, "R4", "word store op counts", 32'(nr*16 + nw), 32'h01);
        chk(rd === 32'd0, "R10", "word store response", rd, 32'd0);
        run_op(1'b0, 1'b0, 16'h0014, '0, 0, rd, nr, nw, lk, us);
        chk(rd === 32'hDEADBEEF, "R4", "word store readback", rd, 32'hDEADBEEF);
        chk(rd === shadow[5], "R5", "word load data", rd, shadow[5]);
    endtask

    task automatic test_rsp_hold();
        logic [31:0] rd; int nr, nw; bit lk, us;
        run_op(1'b0, 1'b1, 16'h0027, '0, 3, rd, nr, nw, lk, us);
        chk(!us, "R9", "response stable while held", {31'd0, us}, 32'd0);
        chk(rd === {24'd0, shadow[9][31:24]}, "R9", "held byte load data", rd,
            {24'd0, shadow[9][31:24]});
        chk(!lk, "R6", "ready during held response", {31'd0, lk}, 32'd0);
    endtask

    task automatic test_all_lanes();
        logic [31:0] rd; int nr, nw; bit lk, us;
        for (int ln = 0; ln < 4; ln++) begin
            run_op(1'b1, 1'b1, 16'h002C + 16'(ln), {24'd0, 8'hC0 + 8'(ln)}, 0, rd, nr, nw, lk, us);
            shadow[11][ln*8 +: 8] = 8'hC0 + 8'(ln);
        end
        run_op(1'b0, 1'b0, 16'h002C, '0, 0, rd, nr, nw, lk, us);
        chk(rd === 32'hC3C2C1C0, "R3", "all four lanes replaced", rd, 32'hC3C2C1C0);
        chk(mem[10] === shadow[10] && mem[12] === shadow[12], "R3", "neighbour words intact",
            mem[12], shadow[12]);
    endtask

    initial begin
        for (int i = 0; i < 16; i++) begin
            mem[i] = 32'h11223344 ^ (32'(i) * 32'h01010101);
            shadow[i] = mem[i];
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        test_byte_loads();
        test_byte_store(3, 1, 8'h5E, 1'b0, "lane1");
        test_byte_store(4, 0, 8'h00, 1'b0, "lane0");
        test_byte_store(6, 3, 8'h9C, 1'b1, "lane3 stalled");
        test_byte_store(7, 2, 8'hFF, 1'b1, "lane2 stalled");
        test_word_store();
        test_rsp_hold();
        test_all_lanes();
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

endmodule